// File: doc/BRIEF.md
# Debug Register Access Message Handler

This block serves register reads and writes that an external debug tool issues through an auxiliary debug port. It receives messages that are already deframed. Each message carries a transfer code, an 8-bit access opcode and a 32-bit data word. The block decodes the opcode into one entry of a small register file and performs the access. It then returns exactly one response message. Its outbound interface uses valid/ready and holds each response until the tool accepts it.

A write request (code 18) is answered with a device-ready message (code 16). A read request (code 17) is answered with an information message (code 19) that carries the register value. An information message also tells the tool that the next access may follow. An opcode that names no register is answered with an error message (code 8), and no register changes. The block takes no new request while a response is still waiting. A request that arrives in that window is discarded and sets a sticky overrun indication.

Top module: `dbg_reg_access`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and overrun is 0. Every register reads back as zero.
- R2: A request with in_code 18 and a mapped opcode is accepted on the clock edge where in_valid and in_ready are both high. One cycle later, out_valid is 1 with out_code 16, out_opcode equal to the request opcode, and out_data equal to 0.
- R3: A request with in_code 17 and a mapped opcode produces, one cycle after acceptance, out_valid with out_code 19, the echoed opcode, and out_data equal to the register value as it stood at acceptance.
- R4: Opcode 0x14 selects register 0. Opcode 0x14+i selects register i for i below NREG (default 4, so opcodes 0x14 to 0x17 are mapped). A write changes only the register it selects.
- R5: A read or write with any other opcode produces a response with out_code 8, whose out_data carries error value 0x05 in bits 4:0 and zeros above. All registers stay unchanged.
- R6: in_ready is 0 while a response is pending. A pending response keeps out_code, out_opcode and out_data stable until out_ready is high. After it is taken, out_valid is 0 and in_ready is 1 in the following cycle.
- R7: A request presented while in_ready is 0 has no effect on the registers and produces no response. It sets overrun, which stays 1 until reset.
- R8: An accepted message whose in_code is neither 17 nor 18 produces no response, leaves in_ready at 1 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Block can take a request |
| in_code | input | 6 | Inbound transfer code |
| in_opcode | input | 8 | Access opcode |
| in_data | input | 32 | Write data |
| out_valid | output | 1 | Response pending |
| out_ready | input | 1 | Tool accepts the response |
| out_code | output | 6 | Response transfer code |
| out_opcode | output | 8 | Echo of the request opcode |
| out_data | output | 32 | Read data, error value or zero |
| overrun | output | 1 | Sticky dropped-request flag |

## Verification
Every response is registered, so it appears exactly one clock after the edge that accepts the request. The bench drives each input on a falling edge and samples one full cycle later, on the next falling edge. A pending response is held for an extra cycle with out_ready low, and the bench checks it again there and also injects a request to provoke an overrun. Release takes one edge, and the bench checks out_valid low and in_ready high at the falling edge that follows.

// File: rtl/dbg_reg_access.sv
module dbg_reg_access #(
  parameter int CODE_W = 6,
  parameter int OP_W   = 8,
  parameter int DATA_W = 32,
  parameter int NREG   = 4,
  parameter logic [OP_W-1:0] BASE_OP = 8'h14,
  parameter logic [4:0] ERR_VAL = 5'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [OP_W-1:0]   out_opcode,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [CODE_W-1:0] C_RD  = CODE_W'(17);
  localparam logic [CODE_W-1:0] C_WR  = CODE_W'(18);
  localparam logic [CODE_W-1:0] C_RDY = CODE_W'(16);
  localparam logic [CODE_W-1:0] C_INF = CODE_W'(19);
  localparam logic [CODE_W-1:0] C_ERR = CODE_W'(8);

  logic [DATA_W-1:0] regs [NREG];
  logic [OP_W-1:0]   off;
  logic [IDX_W-1:0]  idx;
  logic              hit, accept, is_rd, is_wr;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign is_rd    = (in_code == C_RD);
  assign is_wr    = (in_code == C_WR);
  assign off      = in_opcode - BASE_OP;
  assign idx      = off[IDX_W-1:0];
  assign hit      = (in_opcode >= BASE_OP) && (off < OP_W'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_code   <= '0;
      out_opcode <= '0;
      out_data   <= '0;
      overrun    <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_valid && !in_ready) overrun <= 1'b1;
      if (accept && (is_rd || is_wr)) begin
        out_valid  <= 1'b1;
        out_opcode <= in_opcode;
        if (!hit) begin
          out_code <= C_ERR;
          out_data <= DATA_W'(ERR_VAL);
        end else if (is_wr) begin
          regs[idx] <= in_data;
          out_code  <= C_RDY;
          out_data  <= '0;
        end else begin
          out_code <= C_INF;
          out_data <= regs[idx];
        end
      end
    end
  end
endmodule

module dbg_reg_access_chk #(
  parameter int CODE_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun
);
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_data)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> overrun); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_code == CODE_W'(17) || in_code == CODE_W'(18)) |=> out_valid); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code == CODE_W'(16) || out_code == CODE_W'(19) || out_code == CODE_W'(8))); // R5
  AST_IGNORE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_code != CODE_W'(17) && in_code != CODE_W'(18) && !out_valid |=> !out_valid); // R8
endmodule

bind dbg_reg_access dbg_reg_access_chk #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code), .out_data(out_data),
  .overrun(overrun));

// File: tb/dbg_reg_access_tb.sv
module dbg_reg_access_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [5:0] in_code = 0;
  logic [7:0] in_opcode = 0;
  logic [31:0] in_data = 0;
  logic in_ready, out_valid, overrun;
  logic [5:0] out_code;
  logic [7:0] out_opcode;
  logic [31:0] out_data;
  int total = 0, bad = 0;
  logic [31:0] model [4];

  always #10 clk = ~clk;

  dbg_reg_access u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_opcode(in_opcode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_opcode(out_opcode), .out_data(out_data),
    .overrun(overrun));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit mapped(logic [7:0] op);
    return op >= 8'h14 && op < 8'h18;
  endfunction

  // issue request, check response, hold one cycle, release
  task automatic xfer(logic [5:0] code, logic [7:0] op, logic [31:0] d, bit inject);
    logic [5:0] ec;
    logic [31:0] ed;
    @(negedge clk);
    in_valid = 1; in_code = code; in_opcode = op; in_data = d;
    @(negedge clk);
    in_valid = 0;
    if (!mapped(op)) begin ec = 8; ed = 32'h5; end
    else if (code == 18) begin ec = 16; ed = 0; model[op-8'h14] = d; end
    else begin ec = 19; ed = model[op-8'h14]; end
    chk(code == 18 ? "R2 valid" : "R3 valid", out_valid, 1);
    chk(!mapped(op) ? "R5 code" : (code == 18 ? "R2 code" : "R3 code"), out_code, ec);
    chk(!mapped(op) ? "R5 data" : (code == 18 ? "R2 data" : "R4 R3 data"), out_data, ed);
    chk("R2 R3 opcode echo", out_opcode, op);
    chk("R6 busy", in_ready, 0);
    if (inject) begin
      in_valid = 1; in_code = 18; in_opcode = 8'h14; in_data = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    in_valid = 0;
    chk("R6 held valid", out_valid, 1);
    chk("R6 held code", out_code, ec);
    chk("R6 held data", out_data, ed);
    if (inject) chk("R7 overrun set", overrun, 1);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R6 released", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {out_valid, in_ready, overrun}, 3'b010);
    for (int i = 0; i < 4; i++) xfer(17, 8'h14 + 8'(i), 0, 0);   // R1 registers zero
    for (int op = 0; op < 256; op++)                              // R4 R5 write sweep
      xfer(18, 8'(op), 32'h9E37_79B9 * 32'(op + 1), 0);
    for (int op = 0; op < 256; op++) xfer(17, 8'(op), 0, 0);      // R3 R4 R5 read sweep
    chk("R7 no overrun yet", overrun, 0);
    xfer(17, 8'h15, 0, 1);
    xfer(17, 8'h14, 0, 0);                                         // R7 dropped write
    chk("R7 sticky", overrun, 1);
    for (int c = 0; c < 64; c++) begin                             // R8
      if (c == 17 || c == 18) continue;
      @(negedge clk);
      in_valid = 1; in_code = 6'(c); in_opcode = 8'h16; in_data = 32'h1234_5678;
      @(negedge clk);
      in_valid = 0;
      chk("R8 no response", {out_valid, in_ready}, 2'b01);
    end
    for (int i = 0; i < 4; i++) xfer(17, 8'h14 + 8'(i), 0, 0);   // R8 registers intact
    chk("R7 sticky end", overrun, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule